// File: doc/BRIEF.md
# Linked-List Block FIFO Manager

This block manages one direction of a shared dword buffer. The buffer is divided into fixed blocks of four 32-bit dwords. A host joins any set of blocks into a closed ring by writing a next-block link for each block. It then gives the ring to a logical channel by writing one starting block for that channel, which may name any member of the ring. Blocks come from one common pool, so each channel's share of the buffer can be resized without moving data that belongs to other channels.

When a channel is enabled, its write and read positions both start at dword 0 of its starting block. Each accepted write or read moves the matching position forward by one dword. After the last dword of a block, the position moves to dword 0 of the block that the link RAM names. A per-channel dword count detects a full ring (a write is refused) and an empty ring (a read is refused), and the same count drives a watermark flag for each channel.

A parameter picks the direction. A receive instance raises the flag when the fill reaches a programmed high mark. A transmit instance raises it when the fill falls to a programmed low mark.

Top module: `llf_block_fifo`

## Requirements
- R1: After reset, every channel is disabled and `rdValid`, `ovfl`, `udfl` and every bit of `wmFlag` read 0.
- R2: A configuration write (`cfgWrEn`=1) is decoded by `cfgKind`. 0 sets the link of block `cfgAddr` to block `cfgData`. 1 sets the starting block of channel `cfgCh` to `cfgData`. 2 sets the enable of channel `cfgCh` to `cfgData[0]`. 3 sets the watermark level to `cfgData`, counted in dwords.
- R3: Enabling a disabled channel empties it and places both of its positions at dword 0 of its starting block. The first dword written after that is the first dword read back. Writing the enable again to an already enabled channel has no effect.
- R4: Each channel returns its accepted writes in the order they were written. The data of an accepted read is on `rdData`, with `rdValid`=1, in the cycle after the request.
- R5: A ring of N blocks holds exactly 4·N dwords, wherever in the ring the starting block points. Channels that use separate rings do not disturb each other's data.
- R6: A write to an enabled channel that already holds 4·N dwords is refused, leaves the stored data unchanged, and raises `ovfl` for one cycle in the next cycle.
- R7: A read from an enabled, empty channel returns no data (`rdValid`=0) and raises `udfl` for one cycle in the next cycle.
- R8: In the receive variant (`RX_PATH`=1), `wmFlag[c]` is 1 exactly when channel c is enabled and its fill is at or above the watermark level.
- R9: In the transmit variant (`RX_PATH`=0), `wmFlag[c]` is 1 exactly when channel c is enabled and its fill is at or below the watermark level.
- R10: Link writes (kind 0) and starting-block writes (kind 1) are ignored while channel `cfgCh` is enabled.
- R11: Writes and reads addressed to a disabled channel store nothing and raise no `rdValid`, `ovfl` or `udfl`.
- R12: A write and a read to the same channel in the same cycle are both judged on the fill held before that cycle. On an empty channel the read underflows and the write is stored. On a partly filled channel both are carried out and the fill stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | Configuration target: 0 link, 1 start, 2 enable, 3 watermark |
| cfgCh | input | $clog2(NUM_CH) | Channel that the configuration write is for |
| cfgAddr | input | $clog2(NUM_BLK) | Block whose link is written |
| cfgData | input | $clog2(4·NUM_BLK+1) | Configuration value |
| wrEn | input | 1 | Dword write request |
| wrCh | input | $clog2(NUM_CH) | Channel being written |
| wrData | input | DATA_W | Dword to store |
| rdEn | input | 1 | Dword read request |
| rdCh | input | $clog2(NUM_CH) | Channel being read |
| rdValid | output | 1 | `rdData` holds an accepted read |
| rdData | output | DATA_W | Dword read out |
| ovfl | output | 1 | The previous write was refused because the ring was full |
| udfl | output | 1 | The previous read was refused because the ring was empty |
| wmFlag | output | NUM_CH | Per-channel watermark flag |

## Verification
Assertions check on every clock that no channel's fill goes past the pool size. They also check that a refused write leaves the write position where it was, that a read never reports data and underflow together, and that an enable empties the channel. A start write to an enabled channel must leave the stored start in place, and one data address is never written and read in the same cycle. Only the bench's scenarios can show that a ring's capacity matches its programmed length, that the data comes back in order as positions cross block links, and that a rejected link write leaves the ring unchanged. The watermark comparisons of both variants, and the separation of channels under mixed pseudo-random traffic, are also left to those scenarios.

// File: rtl/llf_pkg.sv
package llf_pkg;

  // Each block is four dwords, so the dword offset inside a block takes two bits.
  localparam int LLF_OFS_W = 2;
  localparam int LLF_DW_PER_BLK = 1 << LLF_OFS_W;

  typedef enum logic [1:0] {
    CFG_LINK   = 2'd0,
    CFG_START  = 2'd1,
    CFG_ENABLE = 2'd2,
    CFG_MARK   = 2'd3
  } cfg_kind_e;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic dataWe;
    logic dataRe;
    logic linkWe;
  } llf_strobe_t;

endpackage

// File: rtl/llf_datapath.sv
module llf_datapath
  import llf_pkg::*;
#(
  parameter int NUM_BLK = 64,
  parameter int DATA_W  = 32,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int POS_W  = BLK_W + LLF_OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  llf_strobe_t       strb,
  input  logic [POS_W-1:0]  dataWAddr,
  input  logic [POS_W-1:0]  dataRAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BLK_W-1:0]  linkAddr,
  input  logic [BLK_W-1:0]  linkData,
  input  logic [BLK_W-1:0]  wrBlk,
  input  logic [BLK_W-1:0]  rdBlk,
  output logic [BLK_W-1:0]  wrNext,
  output logic [BLK_W-1:0]  rdNext,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = NUM_BLK * LLF_DW_PER_BLK;

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [BLK_W-1:0]  linkMem [NUM_BLK];

  always_ff @(posedge clk) begin
    if (strb.dataWe) dataMem[dataWAddr] <= wrData;
    if (strb.dataRe) rdData <= dataMem[dataRAddr];
    if (strb.linkWe) linkMem[linkAddr] <= linkData;
  end

  // The write side and the read side each look up the link of their current block.
  assign wrNext = linkMem[wrBlk];
  assign rdNext = linkMem[rdBlk];

  // R12: write and read positions coincide only when a ring is full or empty,
  // and then one of the two requests has already been refused.
  assert_no_rw_collision_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWe && strb.dataRe) |-> (dataWAddr != dataRAddr));

endmodule

// File: rtl/llf_ctrl.sv
module llf_ctrl
  import llf_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_BLK = 64,
  parameter int RX_PATH = 1,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int POS_W  = BLK_W + LLF_OFS_W,
  localparam int FILL_W = $clog2(NUM_BLK * LLF_DW_PER_BLK + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgKind,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [BLK_W-1:0]  cfgAddr,
  input  logic [FILL_W-1:0] cfgData,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrCh,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdCh,
  input  logic [BLK_W-1:0]  wrNext,
  input  logic [BLK_W-1:0]  rdNext,
  output llf_strobe_t       strb,
  output logic [POS_W-1:0]  dataWAddr,
  output logic [POS_W-1:0]  dataRAddr,
  output logic [BLK_W-1:0]  linkAddr,
  output logic [BLK_W-1:0]  linkData,
  output logic [BLK_W-1:0]  wrBlk,
  output logic [BLK_W-1:0]  rdBlk,
  output logic              rdValid,
  output logic              ovfl,
  output logic              udfl,
  output logic [NUM_CH-1:0] wmFlag
);

  localparam logic [FILL_W-1:0] CAP = FILL_W'(NUM_BLK * LLF_DW_PER_BLK);

  logic [POS_W-1:0]  wrPos    [NUM_CH];
  logic [POS_W-1:0]  rdPos    [NUM_CH];
  logic [FILL_W-1:0] fill     [NUM_CH];
  logic [BLK_W-1:0]  startPtr [NUM_CH];
  logic [NUM_CH-1:0] chEn;
  logic [FILL_W-1:0] mark;

  logic wrFull, wrOk, wrBad, rdEmpty, rdOk, rdBad, cfgOpen, enLoad;
  logic [POS_W-1:0] wrPosNext, rdPosNext;

  // Move one dword forward, following the link after the last dword of a block.
  function automatic logic [POS_W-1:0] stepPos(input logic [POS_W-1:0] p,
                                               input logic [BLK_W-1:0] nb);
    if (p[LLF_OFS_W-1:0] == {LLF_OFS_W{1'b1}}) return {nb, {LLF_OFS_W{1'b0}}};
    return p + POS_W'(1);
  endfunction

  always_comb begin
    // Equal positions with a nonzero count mean the write side has gone all the way round the ring.
    wrFull    = (fill[wrCh] != '0) && (wrPos[wrCh] == rdPos[wrCh]);
    wrOk      = wrEn && chEn[wrCh] && !wrFull;
    wrBad     = wrEn && chEn[wrCh] && wrFull;
    rdEmpty   = (fill[rdCh] == '0);
    rdOk      = rdEn && chEn[rdCh] && !rdEmpty;
    rdBad     = rdEn && chEn[rdCh] && rdEmpty;
    cfgOpen   = cfgWrEn && !chEn[cfgCh];
    enLoad    = cfgWrEn && (cfgKind == CFG_ENABLE) && cfgData[0] && !chEn[cfgCh];
    wrBlk     = wrPos[wrCh][POS_W-1:LLF_OFS_W];
    rdBlk     = rdPos[rdCh][POS_W-1:LLF_OFS_W];
    wrPosNext = stepPos(wrPos[wrCh], wrNext);
    rdPosNext = stepPos(rdPos[rdCh], rdNext);

    strb.dataWe = wrOk;
    strb.dataRe = rdOk;
    strb.linkWe = cfgOpen && (cfgKind == CFG_LINK);
    dataWAddr   = wrPos[wrCh];
    dataRAddr   = rdPos[rdCh];
    linkAddr    = cfgAddr;
    linkData    = cfgData[BLK_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chEn    <= '0;
      mark    <= '0;
      ovfl    <= 1'b0;
      udfl    <= 1'b0;
      rdValid <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        wrPos[c]    <= '0;
        rdPos[c]    <= '0;
        fill[c]     <= '0;
        startPtr[c] <= '0;
      end
    end else begin
      ovfl    <= wrBad;
      udfl    <= rdBad;
      rdValid <= rdOk;
      if (cfgWrEn && (cfgKind == CFG_MARK)) mark <= cfgData;
      if (cfgOpen && (cfgKind == CFG_START)) startPtr[cfgCh] <= cfgData[BLK_W-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (wrOk && (wrCh == CH_W'(c))) wrPos[c] <= wrPosNext;
        if (rdOk && (rdCh == CH_W'(c))) rdPos[c] <= rdPosNext;
        fill[c] <= fill[c] + FILL_W'(wrOk && (wrCh == CH_W'(c)))
                           - FILL_W'(rdOk && (rdCh == CH_W'(c)));
        if (cfgWrEn && (cfgKind == CFG_ENABLE) && (cfgCh == CH_W'(c))) begin
          chEn[c] <= cfgData[0];
          if (cfgData[0] && !chEn[c]) begin
            wrPos[c] <= {startPtr[c], {LLF_OFS_W{1'b0}}};
            rdPos[c] <= {startPtr[c], {LLF_OFS_W{1'b0}}};
            fill[c]  <= '0;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (RX_PATH != 0) begin : g_rx
      assign wmFlag[g] = chEn[g] && (fill[g] >= mark);
    end else begin : g_tx
      assign wmFlag[g] = chEn[g] && (fill[g] <= mark);
    end

    // R6: no channel can hold more dwords than the whole pool.
    assert_fill_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
      fill[g] <= CAP);
  end

  // R6: a refused write leaves the write position where it was.
  assert_refused_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrBad && !(cfgWrEn && (cfgKind == CFG_ENABLE)))
      |=> (wrPos[$past(wrCh)] == $past(wrPos[wrCh])));

  // R7: a read never returns data and underflows at the same time.
  assert_read_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && udfl));

  // R3: enabling a channel leaves it enabled and empty.
  assert_enable_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    enLoad |=> (chEn[$past(cfgCh)] && (fill[$past(cfgCh)] == '0)));

  // R10: a start write to an enabled channel leaves the stored start unchanged.
  assert_locked_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgKind == CFG_START) && chEn[cfgCh])
      |=> (startPtr[$past(cfgCh)] == $past(startPtr[cfgCh])));

endmodule

// File: rtl/llf_block_fifo.sv
module llf_block_fifo
  import llf_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_BLK = 64,
  parameter int DATA_W  = 32,
  parameter int RX_PATH = 1,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int POS_W  = BLK_W + LLF_OFS_W,
  localparam int FILL_W = $clog2(NUM_BLK * LLF_DW_PER_BLK + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgKind,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [BLK_W-1:0]  cfgAddr,
  input  logic [FILL_W-1:0] cfgData,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrCh,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdCh,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              ovfl,
  output logic              udfl,
  output logic [NUM_CH-1:0] wmFlag
);

  llf_strobe_t      strb;
  logic [POS_W-1:0] dataWAddr, dataRAddr;
  logic [BLK_W-1:0] linkAddr, linkData, wrBlk, rdBlk, wrNext, rdNext;

  llf_ctrl #(
    .NUM_CH (NUM_CH),
    .NUM_BLK(NUM_BLK),
    .RX_PATH(RX_PATH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgKind  (cfgKind),
    .cfgCh    (cfgCh),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .wrEn     (wrEn),
    .wrCh     (wrCh),
    .rdEn     (rdEn),
    .rdCh     (rdCh),
    .wrNext   (wrNext),
    .rdNext   (rdNext),
    .strb     (strb),
    .dataWAddr(dataWAddr),
    .dataRAddr(dataRAddr),
    .linkAddr (linkAddr),
    .linkData (linkData),
    .wrBlk    (wrBlk),
    .rdBlk    (rdBlk),
    .rdValid  (rdValid),
    .ovfl     (ovfl),
    .udfl     (udfl),
    .wmFlag   (wmFlag)
  );

  llf_datapath #(
    .NUM_BLK(NUM_BLK),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataWAddr(dataWAddr),
    .dataRAddr(dataRAddr),
    .wrData   (wrData),
    .linkAddr (linkAddr),
    .linkData (linkData),
    .wrBlk    (wrBlk),
    .rdBlk    (rdBlk),
    .wrNext   (wrNext),
    .rdNext   (rdNext),
    .rdData   (rdData)
  );

endmodule

// File: tb/llf_block_fifo_tb.sv
module llf_block_fifo_tb;

  localparam int NCH    = 8;
  localparam int NBLK   = 64;
  localparam int CH_W   = $clog2(NCH);
  localparam int BLK_W  = $clog2(NBLK);
  localparam int FILL_W = $clog2(NBLK * 4 + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              cfgWrEn = 1'b0;
  logic [1:0]        cfgKind = '0;
  logic [CH_W-1:0]   cfgCh = '0;
  logic [BLK_W-1:0]  cfgAddr = '0;
  logic [FILL_W-1:0] cfgData = '0;
  logic              wrEn = 1'b0;
  logic [CH_W-1:0]   wrCh = '0;
  logic [31:0]       wrData = '0;
  logic              rdEn = 1'b0;
  logic [CH_W-1:0]   rdCh = '0;

  logic rxValid, rxOvfl, rxUdfl, txValid, txOvfl, txUdfl;
  logic [31:0] rxData, txData;
  logic [NCH-1:0] rxWm, txWm;

  llf_block_fifo #(.NUM_CH(NCH), .NUM_BLK(NBLK), .RX_PATH(1)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgKind(cfgKind), .cfgCh(cfgCh),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .wrEn(wrEn), .wrCh(wrCh), .wrData(wrData),
    .rdEn(rdEn), .rdCh(rdCh), .rdValid(rxValid), .rdData(rxData), .ovfl(rxOvfl),
    .udfl(rxUdfl), .wmFlag(rxWm));

  llf_block_fifo #(.NUM_CH(NCH), .NUM_BLK(NBLK), .RX_PATH(0)) u_dutTx (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgKind(cfgKind), .cfgCh(cfgCh),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .wrEn(wrEn), .wrCh(wrCh), .wrData(wrData),
    .rdEn(rdEn), .rdCh(rdCh), .rdValid(txValid), .rdData(txData), .ovfl(txOvfl),
    .udfl(txUdfl), .wmFlag(txWm));

  // Reference model: one queue per channel and the ring capacity the bench programmed.
  int unsigned mq [NCH][$];
  int          capOf [NCH];
  bit          enOf [NCH];
  int          markLvl = 0;
  bit          expValid = 0, expOvf = 0, expUdf = 0;
  int unsigned expData = 0;
  int          checks = 0, errors = 0;
  string       curReq = "R1";
  int unsigned seqVal = 32'hA000_0000;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] expWm(input bit rx);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++)
      v[c] = enOf[c] && (rx ? (int'(mq[c].size()) >= markLvl) : (int'(mq[c].size()) <= markLvl));
    return v;
  endfunction

  task automatic compareAll();
    check(curReq, "rx rdValid", longint'(rxValid), longint'(expValid));
    check(curReq, "tx rdValid", longint'(txValid), longint'(expValid));
    check(curReq, "rx ovfl", longint'(rxOvfl), longint'(expOvf));
    check(curReq, "tx ovfl", longint'(txOvfl), longint'(expOvf));
    check(curReq, "rx udfl", longint'(rxUdfl), longint'(expUdf));
    check(curReq, "tx udfl", longint'(txUdfl), longint'(expUdf));
    if (expValid) begin
      check(curReq, "rx rdData", longint'(rxData), longint'(expData));
      check(curReq, "tx rdData", longint'(txData), longint'(expData));
    end
    check("R8", "rx wmFlag", longint'(rxWm), longint'(expWm(1'b1)));
    check("R9", "tx wmFlag", longint'(txWm), longint'(expWm(1'b0)));
  endtask

  // One clock: inputs are already driven, the model is updated at the edge, outputs are compared at the falling edge.
  task automatic cycle();
    bit wOk;
    @(posedge clk);
    expValid = 0; expOvf = 0; expUdf = 0;
    wOk = wrEn && enOf[wrCh] && (int'(mq[wrCh].size()) < capOf[wrCh]);
    if (wrEn && enOf[wrCh] && !wOk) expOvf = 1;
    if (rdEn && enOf[rdCh]) begin
      if (mq[rdCh].size() == 0) expUdf = 1;
      else begin expValid = 1; expData = mq[rdCh][0]; end
    end
    if (expValid) void'(mq[rdCh].pop_front());
    if (wOk) mq[wrCh].push_back(wrData);
    if (cfgWrEn && cfgKind == 2'd3) markLvl = int'(cfgData);
    if (cfgWrEn && cfgKind == 2'd2) begin
      if (cfgData[0] && !enOf[cfgCh]) mq[cfgCh].delete();
      enOf[cfgCh] = cfgData[0];
    end
    @(negedge clk);
    compareAll();
    cfgWrEn = 0; wrEn = 0; rdEn = 0;
  endtask

  task automatic cfg(input int kind, input int ch, input int addr, input int data);
    cfgWrEn = 1; cfgKind = 2'(kind); cfgCh = CH_W'(ch); cfgAddr = BLK_W'(addr);
    cfgData = FILL_W'(data);
    cycle();
  endtask

  task automatic wr(input int ch);
    wrEn = 1; wrCh = CH_W'(ch); wrData = seqVal; seqVal++;
    cycle();
  endtask

  task automatic rd(input int ch);
    rdEn = 1; rdCh = CH_W'(ch);
    cycle();
  endtask

  task automatic wrRd(input int wch, input int rch);
    wrEn = 1; wrCh = CH_W'(wch); wrData = seqVal; seqVal++;
    rdEn = 1; rdCh = CH_W'(rch);
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int c = 0; c < NCH; c++) begin capOf[c] = 0; enOf[c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: state right after reset
    curReq = "R1";
    compareAll();
    cycle();

    // R2: ring for channel 0 is 5->9->2->7->5, starting in the middle at block 9 (R5)
    curReq = "R2";
    cfg(0, 0, 5, 9); cfg(0, 0, 9, 2); cfg(0, 0, 2, 7); cfg(0, 0, 7, 5);
    cfg(1, 0, 0, 9); capOf[0] = 16;
    // channel 1 ring 10..15 back to 10, starting at block 12
    for (int b = 10; b < 16; b++) cfg(0, 1, b, (b == 15) ? 10 : b + 1);
    cfg(1, 1, 0, 12); capOf[1] = 24;
    cfg(3, 0, 0, 5);

    // R3: enabling empties the channel and starts both positions at the start block
    curReq = "R3";
    cfg(2, 0, 0, 1); cfg(2, 1, 0, 1);
    wr(0); rd(0);

    // R4: ordering across block links, interleaved with another channel
    curReq = "R4";
    for (int i = 0; i < 10; i++) begin wr(0); if (i % 3 == 0) wr(1); end
    for (int i = 0; i < 3; i++) rd(0);
    rd(1);

    // R5 and R6: fill channel 0 to its ring size, then one more write
    curReq = "R5";
    while (int'(mq[0].size()) < 16) wr(0);
    curReq = "R6";
    wr(0); wr(0);
    // R7: drain, then read once more
    curReq = "R5";
    while (mq[0].size() > 0) rd(0);
    curReq = "R7";
    rd(0); rd(0);

    // R10: link and start writes for an enabled channel are dropped
    curReq = "R10";
    cfg(0, 0, 7, 10);
    cfg(1, 0, 0, 10);
    cfg(2, 0, 0, 1);
    for (int i = 0; i < 17; i++) wr(0);
    while (mq[0].size() > 0) rd(0);
    while (mq[1].size() > 0) rd(1);

    // R11: traffic to a disabled channel
    curReq = "R11";
    wr(2); rd(2); wrRd(2, 2); rd(2);

    // R12: same-cycle write and read on an empty channel, then on a partly filled one
    curReq = "R12";
    wrRd(0, 0); wrRd(0, 0); wrRd(0, 0); rd(0); rd(0);

    // R3: re-enabling after a disable throws away what was held
    curReq = "R3";
    wr(1); wr(1); wr(1);
    cfg(2, 1, 0, 0);
    rd(1);
    cfg(2, 1, 0, 1);
    rd(1); wr(1); rd(1);

    // R8 / R9: move the watermark and sweep the fill through it
    curReq = "R8";
    cfg(3, 0, 0, 3);
    for (int i = 0; i < 6; i++) wr(1);
    for (int i = 0; i < 6; i++) rd(1);

    // Mixed pseudo-random traffic on channels 0 and 1 (R4, R5, R6, R7, R12)
    curReq = "R4";
    lf = 16'hACE1;
    for (int i = 0; i < 800; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wrEn = lf[0] | (lf[3] & ~lf[9]); wrCh = CH_W'(lf[4]); wrData = seqVal; seqVal++;
      rdEn = lf[1] | lf[7]; rdCh = CH_W'(lf[5]);
      cycle();
    end
    curReq = "R5";
    while (mq[0].size() > 0) rd(0);
    while (mq[1].size() > 0) rd(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule